// File: doc/BRIEF.md
# Forward-Path Crossbar Arbiter with Per-Pair Queues

This block carries transfer requests from eight requesting cores to nine destinations: eight cache banks at indices 0 to 7 and one non-cacheable unit at index 8. A source posts one request per cycle, tagged with a destination index and carrying a payload. The request is parked in a two-entry queue owned by that single source–destination pair. Each destination then picks one source per cycle from the heads of its eight queues and delivers the winning payload on its own output, together with the index of the source that sent it.

Every request goes through four stages: a request register, queue entry with arbitration, selection (the queue head is popped into a select register), and transmission (the output register). A source learns through a per-pair full flag that a queue has no room, and a destination applies back-pressure through its ready input. The return path from banks to cores is a separate block.

Top module: `xbar_fwd_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, every destination valid and every pair full flag is low.
- R2: A request accepted at a clock edge appears on its destination's output exactly three edges later, with dst_valid high, the sender's index on the source field and the payload unchanged.
- R3: A pair's full flag (bit source*9+destination) rises the cycle after the pair's second outstanding acceptance. A request posted to a full pair is dropped and never delivered. The flag clears once an entry is selected.
- R4: While dst_ready of a destination is low, none of its queues is selected, so nothing is delivered there two edges later. Queued entries are kept and delivered after ready returns.
- R5: Payloads of one source–destination pair come out in the order they were accepted, each accepted payload exactly once.
- R6: Each destination grants round-robin. After it grants source g, the next grant goes to the first waiting source found from g+1 upward, wrapping past 7 to 0.
- R7: Different destinations deliver in the same cycle without interfering, including eight sources each sending to a distinct bank in one cycle.
- R8: A destination delivers at most one payload per cycle, and with a backlog it delivers one payload on every consecutive cycle.
- R9: Destination index 8 (the non-cacheable unit) behaves like a bank. A destination field of 9 or more is ignored: nothing is queued and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | N_SRC | Per-source request strobe |
| src_dst | input | N_SRC*4 | Destination index per source, 4 bits each, source s at bits s*4 and up |
| src_data | input | N_SRC*DATA_W | Payload per source |
| pair_full | output | N_SRC*N_DST | Pair queue full, bit source*N_DST+destination |
| dst_ready | input | N_DST | Per-destination ready |
| dst_valid | output | N_DST | Delivery strobe per destination |
| dst_data | output | N_DST*DATA_W | Delivered payload per destination |
| dst_src | output | N_DST*3 | Index of the sender per destination |

## Verification
Within one cycle, a pair's queue can be popped by its destination's selection and receive a new acceptance from its source. Its credit count then has to stay level, neither blocking the source early nor letting a third entry in. The bench provokes this with a long pseudo-random phase: all sources post to random destinations while each destination's ready flickers, so accepts, pops and stalls land on the same pair in the same cycle. A scoreboard of per-pair expected queues, filled by the driver only for requests it sees accepted, judges every delivery and flags any payload that is lost, reordered or extra.

// File: rtl/xbar_fwd_pkg.sv
package xbar_fwd_pkg;
   localparam int ARB_ROUND_ROBIN = 0;
   localparam int ARB_FIXED_LOW   = 1;
endpackage

// File: rtl/xbar_pair_fifo.sv
module xbar_pair_fifo #(
   parameter int DEPTH  = 2,
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic              head_vld,
   output logic [DATA_W-1:0] head_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [LVL_W-1:0]  level;
   logic              do_push, do_pop;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign do_pop  = pop && (level != '0);
   assign do_push = push && ((level != LVL_W'(DEPTH)) || do_pop);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         if (do_push && !do_pop)      level <= level + 1'b1;
         else if (!do_push && do_pop) level <= level - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   assign head_vld  = (level != '0);
   assign head_data = mem[rd_ptr];
endmodule

// File: rtl/xbar_rr_pick.sv
module xbar_rr_pick #(
   parameter int N    = 8,
   parameter int MODE = xbar_fwd_pkg::ARB_ROUND_ROBIN
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic [N-1:0]         req,
   output logic [N-1:0]         gnt,
   output logic [$clog2(N)-1:0] gnt_idx
);
   localparam int IDX_W = $clog2(N);

   if (MODE == xbar_fwd_pkg::ARB_ROUND_ROBIN) begin : g_rr
      logic [IDX_W-1:0] ptr;
      logic             found;

      always_comb begin
         gnt     = '0;
         gnt_idx = '0;
         found   = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (!found && req[(int'(ptr) + i) % N]) begin
               found                   = 1'b1;
               gnt[(int'(ptr) + i) % N] = 1'b1;
               gnt_idx                 = IDX_W'((int'(ptr) + i) % N);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (rst)
            ptr <= '0;
         else if (found)
            ptr <= (gnt_idx == IDX_W'(N - 1)) ? '0 : gnt_idx + 1'b1;
      end
   end else begin : g_fixed
      logic found;
      always_comb begin
         gnt     = '0;
         gnt_idx = '0;
         found   = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (!found && req[i]) begin
               found   = 1'b1;
               gnt[i]  = 1'b1;
               gnt_idx = IDX_W'(i);
            end
         end
      end
   end
endmodule

// File: rtl/xbar_dst_lane.sv
module xbar_dst_lane #(
   parameter int N_SRC    = 8,
   parameter int DATA_W   = 16,
   parameter int ARB_MODE = xbar_fwd_pkg::ARB_ROUND_ROBIN
)(
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ready,
   input  logic [N_SRC-1:0]         head_vld,
   input  logic [N_SRC*DATA_W-1:0]  head_data,
   output logic [N_SRC-1:0]         pop,
   output logic                     out_vld,
   output logic [DATA_W-1:0]        out_data,
   output logic [$clog2(N_SRC)-1:0] out_src
);
   localparam int SRC_W = $clog2(N_SRC);

   logic [N_SRC-1:0]  req, gnt;
   logic [SRC_W-1:0]  gidx;
   logic              sel_vld;
   logic [DATA_W-1:0] sel_data;
   logic [SRC_W-1:0]  sel_src;

   assign req = head_vld & {N_SRC{ready}};

   xbar_rr_pick #(.N(N_SRC), .MODE(ARB_MODE)) u_pick (
      .clk     (clk),
      .rst     (rst),
      .req     (req),
      .gnt     (gnt),
      .gnt_idx (gidx)
   );

   assign pop = gnt;

   // selection stage then transmission stage
   always_ff @(posedge clk) begin
      if (rst) begin
         sel_vld  <= 1'b0;
         sel_data <= '0;
         sel_src  <= '0;
         out_vld  <= 1'b0;
         out_data <= '0;
         out_src  <= '0;
      end else begin
         sel_vld  <= |gnt;
         sel_data <= head_data[gidx*DATA_W +: DATA_W];
         sel_src  <= gidx;
         out_vld  <= sel_vld;
         out_data <= sel_data;
         out_src  <= sel_src;
      end
   end
endmodule

// File: rtl/xbar_fwd_arbiter.sv
module xbar_fwd_arbiter #(
   parameter int N_SRC    = 8,
   parameter int N_DST    = 9,
   parameter int DATA_W   = 16,
   parameter int DEPTH    = 2,
   parameter int ARB_MODE = xbar_fwd_pkg::ARB_ROUND_ROBIN
)(
   input  logic                             clk,
   input  logic                             rst,
   input  logic [N_SRC-1:0]                 src_valid,
   input  logic [N_SRC*$clog2(N_DST)-1:0]   src_dst,
   input  logic [N_SRC*DATA_W-1:0]          src_data,
   output logic [N_SRC*N_DST-1:0]           pair_full,
   input  logic [N_DST-1:0]                 dst_ready,
   output logic [N_DST-1:0]                 dst_valid,
   output logic [N_DST*DATA_W-1:0]          dst_data,
   output logic [N_DST*$clog2(N_SRC)-1:0]   dst_src
);
   localparam int DST_W  = $clog2(N_DST);
   localparam int SRC_W  = $clog2(N_SRC);
   localparam int N_PAIR = N_SRC * N_DST;
   localparam int LVL_W  = $clog2(DEPTH + 1);

   if (N_SRC < 2) begin : g_chk_src
      $error("xbar_fwd_arbiter: N_SRC must be at least 2");
   end
   if (N_DST < 2) begin : g_chk_dst
      $error("xbar_fwd_arbiter: N_DST must be at least 2");
   end
   if (DEPTH < 2) begin : g_chk_depth
      $error("xbar_fwd_arbiter: DEPTH must be at least 2");
   end
   if (ARB_MODE != xbar_fwd_pkg::ARB_ROUND_ROBIN && ARB_MODE != xbar_fwd_pkg::ARB_FIXED_LOW) begin : g_chk_mode
      $error("xbar_fwd_arbiter: unknown ARB_MODE");
   end

   logic [N_PAIR-1:0]        pop_vec;
   logic [N_PAIR-1:0]        head_vld_vec;
   logic [N_PAIR*DATA_W-1:0] head_data_flat;

   // request stage and per-pair storage
   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic [DST_W-1:0]  dsel;
      logic [N_DST-1:0]  hit, full_row, take, rq_hit;
      logic [DATA_W-1:0] rq_data;

      assign dsel     = src_dst[s*DST_W +: DST_W];
      assign full_row = pair_full[s*N_DST +: N_DST];

      for (genvar d = 0; d < N_DST; d++) begin : g_hit
         assign hit[d] = (dsel == DST_W'(d));
      end

      assign take = {N_DST{src_valid[s]}} & hit & ~full_row;

      always_ff @(posedge clk) begin
         if (rst) begin
            rq_hit  <= '0;
            rq_data <= '0;
         end else begin
            rq_hit  <= take;
            rq_data <= src_data[s*DATA_W +: DATA_W];
         end
      end

      for (genvar d = 0; d < N_DST; d++) begin : g_pair
         localparam int P = s * N_DST + d;
         logic [LVL_W-1:0] credit;

         // credit covers the entry in flight in the request register
         always_ff @(posedge clk) begin
            if (rst)
               credit <= '0;
            else if (take[d] && !pop_vec[P])
               credit <= credit + 1'b1;
            else if (!take[d] && pop_vec[P])
               credit <= credit - 1'b1;
         end

         assign pair_full[P] = (credit == LVL_W'(DEPTH));

         xbar_pair_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (rq_hit[d]),
            .push_data (rq_data),
            .pop       (pop_vec[P]),
            .head_vld  (head_vld_vec[P]),
            .head_data (head_data_flat[P*DATA_W +: DATA_W])
         );
      end
   end

   // per-destination arbitration, selection and transmission
   for (genvar d = 0; d < N_DST; d++) begin : g_dst
      logic [N_SRC-1:0]        lane_vld, lane_pop;
      logic [N_SRC*DATA_W-1:0] lane_data;

      for (genvar s = 0; s < N_SRC; s++) begin : g_gather
         assign lane_vld[s]                     = head_vld_vec[s*N_DST + d];
         assign lane_data[s*DATA_W +: DATA_W]   = head_data_flat[(s*N_DST + d)*DATA_W +: DATA_W];
         assign pop_vec[s*N_DST + d]            = lane_pop[s];
      end

      xbar_dst_lane #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ARB_MODE(ARB_MODE)) u_lane (
         .clk       (clk),
         .rst       (rst),
         .ready     (dst_ready[d]),
         .head_vld  (lane_vld),
         .head_data (lane_data),
         .pop       (lane_pop),
         .out_vld   (dst_valid[d]),
         .out_data  (dst_data[d*DATA_W +: DATA_W]),
         .out_src   (dst_src[d*SRC_W +: SRC_W])
      );
   end
endmodule

// File: rtl/xbar_fwd_arbiter_chk.sv
module xbar_fwd_arbiter_chk #(
   parameter int N_SRC = 8,
   parameter int N_DST = 9
)(
   input logic                   clk,
   input logic                   rst,
   input logic [N_DST-1:0]       dst_ready,
   input logic [N_DST-1:0]       dst_valid,
   input logic [N_SRC*N_DST-1:0] pair_full,
   input logic [N_SRC*N_DST-1:0] pop_vec,
   input logic [N_SRC*N_DST-1:0] head_vld_vec
);
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (dst_valid == '0) && (pair_full == '0));

   for (genvar d = 0; d < N_DST; d++) begin : g_dst
      logic [N_SRC-1:0] grants;
      for (genvar s = 0; s < N_SRC; s++) begin : g_col
         assign grants[s] = pop_vec[s*N_DST + d];
      end

      p_ready_block_r4: assert property (@(posedge clk) disable iff (rst)
         !dst_ready[d] |-> ##2 !dst_valid[d]);

      p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
         $onehot0(grants));
   end

   for (genvar p = 0; p < N_SRC*N_DST; p++) begin : g_pair
      p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
         pair_full[p] && !pop_vec[p] |=> pair_full[p]);

      p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
         pop_vec[p] |-> head_vld_vec[p]);
   end
endmodule

bind xbar_fwd_arbiter xbar_fwd_arbiter_chk #(.N_SRC(N_SRC), .N_DST(N_DST)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .dst_ready    (dst_ready),
   .dst_valid    (dst_valid),
   .pair_full    (pair_full),
   .pop_vec      (pop_vec),
   .head_vld_vec (head_vld_vec)
);

// File: tb/tb_xbar_fwd_arbiter.sv
module tb_xbar_fwd_arbiter;
   localparam int NS = 8, ND = 9, DW = 16, DSTW = 4, SRCW = 3, NP = NS * ND;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst = 1'b1;
   logic [NS-1:0]      src_valid = '0;
   logic [NS*DSTW-1:0] src_dst = '0;
   logic [NS*DW-1:0]   src_data = '0;
   logic [NP-1:0]      pair_full;
   logic [ND-1:0]      dst_ready = '1;
   logic [ND-1:0]      dst_valid;
   logic [ND*DW-1:0]   dst_data;
   logic [ND*SRCW-1:0] dst_src;

   xbar_fwd_arbiter dut (
      .clk(clk), .rst(rst), .src_valid(src_valid), .src_dst(src_dst), .src_data(src_data),
      .pair_full(pair_full), .dst_ready(dst_ready), .dst_valid(dst_valid),
      .dst_data(dst_data), .dst_src(dst_src)
   );

   int checks = 0, fails = 0, cyc = 0, ord_dst = -1;
   bit done = 1'b0;
   logic [DW-1:0] exp_q [NP][$];
   int ord_list[$];
   int ord_cyc[$];
   logic [15:0] tag = 16'h0100;
   int unsigned rng = 32'h1234_5678;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int unsigned next_rng();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   task automatic set_req(input int s, input int d);
      src_valid[s] = 1'b1;
      src_dst[s*DSTW +: DSTW] = DSTW'(d);
      src_data[s*DW +: DW] = tag;
      tag = tag + 16'd1;
   endtask

   // driver: record what the design will accept, then apply one edge
   task automatic launch(output logic [NS-1:0] acc);
      acc = '0;
      for (int s = 0; s < NS; s++) begin
         int d;
         d = int'(src_dst[s*DSTW +: DSTW]);
         if (src_valid[s] && d < ND && !pair_full[s*ND + d]) begin
            acc[s] = 1'b1;
            exp_q[s*ND + d].push_back(src_data[s*DW +: DW]);
         end
      end
      @(posedge clk);
      @(negedge clk);
      src_valid = '0;
   endtask

   // monitor: scoreboard comparison of every delivery
   always @(negedge clk) begin
      if (!rst) begin
         for (int d = 0; d < ND; d++) begin
            if (dst_valid[d]) begin
               int s, p;
               logic [DW-1:0] e;
               s = int'(dst_src[d*SRCW +: SRCW]);
               p = s * ND + d;
               if (exp_q[p].size() == 0) begin
                  check(1'b0, "R5", "unexpected delivery on pair", p, -1);
               end else begin
                  e = exp_q[p].pop_front();
                  check(dst_data[d*DW +: DW] == e, "R5", "pair payload", int'(dst_data[d*DW +: DW]), int'(e));
               end
               if (d == ord_dst) begin
                  ord_list.push_back(s);
                  ord_cyc.push_back(cyc);
               end
            end
         end
      end
      cyc++;
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R5 watchdog: actual no completion, expected completion");
         summary();
         $finish;
      end
   end

   task automatic run_order(input int s_list[$], input int exp_list[$], input string req);
      logic [NS-1:0] acc;
      bit consec;
      dst_ready[6] = 1'b0;
      foreach (s_list[i]) set_req(s_list[i], 6);
      launch(acc);
      repeat (2) @(negedge clk);
      ord_list.delete();
      ord_cyc.delete();
      ord_dst = 6;
      dst_ready[6] = 1'b1;
      repeat (14) @(negedge clk);
      ord_dst = -1;
      check(ord_list.size() == exp_list.size(), req, "grant count", ord_list.size(), exp_list.size());
      for (int i = 0; i < exp_list.size() && i < ord_list.size(); i++)
         check(ord_list[i] == exp_list[i], req, "grant order source", ord_list[i], exp_list[i]);
      consec = 1'b1;
      for (int i = 1; i < ord_cyc.size(); i++)
         if (ord_cyc[i] != ord_cyc[i-1] + 1) consec = 1'b0;
      check(consec, "R8", "back-to-back deliveries", consec, 1);
   endtask

   initial begin
      logic [NS-1:0] acc;
      logic [DW-1:0] v;
      bit seen;
      int n, left;

      repeat (3) @(negedge clk);
      check(dst_valid == '0, "R1", "dst_valid in reset", int'(dst_valid), 0);
      check(pair_full == '0, "R1", "pair_full in reset", int'(|pair_full), 0);
      rst = 1'b0;
      @(negedge clk);
      check(dst_valid == '0 && pair_full == '0, "R1", "idle after reset", int'(dst_valid), 0);

      // R2: three-edge latency, source 2 to bank 5
      v = tag;
      set_req(2, 5);
      launch(acc);
      check(acc[2], "R2", "accepted", int'(acc[2]), 1);
      repeat (2) @(negedge clk);
      check(!dst_valid[5], "R2", "early delivery", int'(dst_valid[5]), 0);
      @(negedge clk);
      check(dst_valid[5], "R2", "delivered on third edge", int'(dst_valid[5]), 1);
      check(dst_src[5*SRCW +: SRCW] == 3'd2, "R2", "source field", int'(dst_src[5*SRCW +: SRCW]), 2);
      check(dst_data[5*DW +: DW] == v, "R2", "payload", int'(dst_data[5*DW +: DW]), int'(v));

      // R9: non-cacheable destination 8
      v = tag;
      set_req(7, 8);
      launch(acc);
      repeat (3) @(negedge clk);
      check(dst_valid[8] && dst_src[8*SRCW +: SRCW] == 3'd7, "R9", "delivery to index 8", int'(dst_valid), 9'h100);
      check(dst_data[8*DW +: DW] == v, "R9", "payload to index 8", int'(dst_data[8*DW +: DW]), int'(v));

      // R9: out-of-range destination ignored
      set_req(0, 12);
      launch(acc);
      seen = 1'b0;
      repeat (6) begin
         @(negedge clk);
         if (dst_valid != '0 || pair_full != '0) seen = 1'b1;
      end
      check(!seen, "R9", "activity from index 12", int'(seen), 0);

      // R7: eight sources to eight distinct banks at once
      for (int s = 0; s < NS; s++) set_req(s, s);
      launch(acc);
      repeat (3) @(negedge clk);
      check(dst_valid == 9'h0FF, "R7", "simultaneous deliveries", int'(dst_valid), 9'h0FF);

      // R3/R4: fill pair (4,1) while bank 1 stalls
      dst_ready[1] = 1'b0;
      set_req(4, 1); launch(acc);
      set_req(4, 1); launch(acc);
      check(pair_full[4*ND + 1], "R3", "full after two", int'(pair_full[4*ND + 1]), 1);
      set_req(4, 1); launch(acc);
      check(!acc[4], "R3", "third post accepted", int'(acc[4]), 0);
      seen = 1'b0;
      repeat (8) begin
         @(negedge clk);
         if (dst_valid[1]) seen = 1'b1;
      end
      check(!seen, "R4", "delivery while not ready", int'(seen), 0);
      check(pair_full[4*ND + 1], "R4", "entries retained", int'(pair_full[4*ND + 1]), 1);
      dst_ready[1] = 1'b1;
      n = 0;
      repeat (8) begin
         @(negedge clk);
         if (dst_valid[1]) n++;
      end
      check(n == 2, "R3", "deliveries after release", n, 2);
      check(!pair_full[4*ND + 1], "R3", "full cleared", int'(pair_full[4*ND + 1]), 0);

      // R6: round-robin on bank 6; its last grant was source 6
      run_order('{0, 1, 2, 3, 4, 5, 6, 7}, '{7, 0, 1, 2, 3, 4, 5, 6}, "R6");
      run_order('{2, 5}, '{2, 5}, "R6");
      run_order('{3, 7}, '{7, 3}, "R6");

      // R5: pseudo-random traffic with flickering ready
      repeat (400) begin
         int unsigned a, b, c;
         a = next_rng(); b = next_rng(); c = next_rng();
         dst_ready = ~(ND'(b) & ND'(c));
         for (int s = 0; s < NS; s++)
            if (a[s]) set_req(s, int'((c >> (s*3)) % 9));
         launch(acc);
      end
      dst_ready = '1;
      repeat (30) @(negedge clk);
      left = 0;
      for (int p = 0; p < NP; p++) left += exp_q[p].size();
      check(left == 0, "R5", "undelivered payloads", left, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule